// File: doc/BRIEF.md
# Keyed Write Guard for Two Control Registers

This block keeps two control registers, a clock-control register and a power-control register, safe from stray bus writes. Each register can only change through a three-write sequence on the register bus. First a fixed 32-bit arming key goes to the register's arming address. Next the new value goes to the register's own address. Last a fixed 32-bit confirming key goes to the register's confirming address. The value from the middle write waits in a shadow register. It becomes the live value only when the confirming key arrives.

Any write that breaks a sequence that is under way cancels it and discards the shadow value. Each register has its own sequencer, and a write to the other register's addresses also counts as a break. A broken sequence sets a sticky error flag, which the `err_clr` input clears. The two live values can be read by address. All other addresses, including the key locations, read as zero. When a value of zero is committed to the power-control register, the block raises a power-down request for exactly one cycle.

Top module: `prot_reg_guard`

## Requirements
- R1: After reset, the clock register reads 0x00000021 and the power register reads 0x00000003. `err_flag` and `pd_req` are low and both sequencers are idle, so a confirming key written after reset commits nothing and sets the error flag.
- R2: The clock register (address 0x014) takes a new value only after this sequence: 0x000000AA to 0x010, then the value to 0x014, then 0x00000055 to 0x018. The new value is readable in the cycle after the confirming write.
- R3: The power register (address 0x024) follows the same rule with arming key 0x00000001 at 0x020 and confirming key 0x000000F4 at 0x028.
- R4: After the arming write and the data write, but before the confirming write, the register still reads its old value.
- R5: A wrong arming key or a wrong confirming key cancels the sequence, sets `err_flag` and leaves the register unchanged.
- R6: A write to a register address or a confirming address while that register's sequencer is idle sets `err_flag` and changes nothing.
- R7: Any write to an address outside the register's three addresses cancels a sequence that is under way. The cancelled shadow value is lost, so a later correct confirming key commits nothing and sets `err_flag` again.
- R8: The sequencers are independent. A write to one register's addresses cancels a sequence under way for the other register and sets `err_flag`.
- R9: `err_flag` stays high until a cycle with `err_clr` high. If a breaking write and `err_clr` fall in the same cycle, the flag stays set.
- R10: `pd_req` is high for exactly one cycle, the cycle after a confirming write that commits 0x00000000 to the power register. A nonzero power value does not raise it, and neither does any clock register value.
- R11: `rd_data` shows the live value of the register whose address is on `rd_addr`, combinationally. The four key addresses and all unmapped addresses read zero.
- R12: While both sequencers are idle, writes to unmapped addresses leave `err_flag` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 12 | Write address |
| bus_wdata | input | 32 | Write data |
| err_clr | input | 1 | Clears the sticky error flag |
| rd_addr | input | 12 | Read address |
| rd_data | output | 32 | Live value at rd_addr, zero elsewhere |
| err_flag | output | 1 | Sticky sequence-violation flag |
| pd_req | output | 1 | One-cycle power-down request |

## Verification
In one cycle, a sequence-breaking write can set the error flag while `err_clr` tries to clear it. The bench causes this by writing straight to the clock register address with `err_clr` high, and expects the flag to stay set. A single write can also cancel the sequence under way for one register and count as an illegal idle access for the other. The bench arms the power register, writes the clock data address, and then checks that both registers keep their values and the error is raised.

// File: rtl/prg_pkg.sv
package prg_pkg;
    localparam int PRG_DW = 32;
    localparam int NCH    = 2;
    localparam int CH_CLK = 0;
    localparam int CH_PWR = 1;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ARMED = 2'd1,
        SEQ_HELD  = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e          st;
        logic [PRG_DW-1:0]   shadow;
        logic [PRG_DW-1:0]   live;
    } seq_regs_t;

    typedef struct packed {
        logic err;
        logic pd;
    } ctl_regs_t;
endpackage

// File: rtl/prg_decode.sv
module prg_decode
    import prg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [NCH-1:0][ADDR_W-1:0] PRE_ADDRS  = '0,
    parameter logic [NCH-1:0][ADDR_W-1:0] REG_ADDRS  = '0,
    parameter logic [NCH-1:0][ADDR_W-1:0] POST_ADDRS = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NCH-1:0]    hit_pre,
    output logic [NCH-1:0]    hit_reg,
    output logic [NCH-1:0]    hit_post
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_dec
        assign hit_pre[ch]  = (addr == PRE_ADDRS[ch]);
        assign hit_reg[ch]  = (addr == REG_ADDRS[ch]);
        assign hit_post[ch] = (addr == POST_ADDRS[ch]);
    end
endmodule

// File: rtl/prg_sequencer.sv
module prg_sequencer
    import prg_pkg::*;
#(
    parameter logic [PRG_DW-1:0] PRE_KEY  = '0,
    parameter logic [PRG_DW-1:0] POST_KEY = '0,
    parameter logic [PRG_DW-1:0] RST_VAL  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PRG_DW-1:0] wdata,
    input  logic              hit_pre,
    input  logic              hit_reg,
    input  logic              hit_post,
    output logic [PRG_DW-1:0] live,
    output logic [PRG_DW-1:0] commit_val,
    output logic              commit,
    output logic              abort
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        abort  = 1'b0;
        commit = 1'b0;
        if (wr_en) begin
            case (r_q.st)
                SEQ_IDLE: begin
                    if (hit_pre) begin
                        if (wdata == PRE_KEY) r_d.st = SEQ_ARMED;
                        else                  abort  = 1'b1;
                    end else if (hit_reg || hit_post) begin
                        abort = 1'b1;
                    end
                end
                SEQ_ARMED: begin
                    if (hit_reg) begin
                        r_d.shadow = wdata;
                        r_d.st     = SEQ_HELD;
                    end else begin
                        abort = 1'b1;
                    end
                end
                SEQ_HELD: begin
                    if (hit_post && (wdata == POST_KEY)) begin
                        r_d.live   = r_q.shadow;
                        r_d.st     = SEQ_IDLE;
                        r_d.shadow = '0;
                        commit     = 1'b1;
                    end else begin
                        abort = 1'b1;
                    end
                end
                default: r_d.st = SEQ_IDLE;
            endcase
        end
        if (abort) begin
            r_d.st     = SEQ_IDLE;
            r_d.shadow = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= SEQ_IDLE;
            r_q.shadow <= '0;
            r_q.live   <= RST_VAL;
        end else begin
            r_q <= r_d;
        end
    end

    assign live       = r_q.live;
    assign commit_val = r_q.shadow;
endmodule

// File: rtl/prg_readmux.sv
module prg_readmux
    import prg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [NCH-1:0][ADDR_W-1:0] REG_ADDRS = '0
) (
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [NCH-1:0][PRG_DW-1:0]   live,
    output logic [PRG_DW-1:0]            rd_data
);
    always_comb begin
        rd_data = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            if (rd_addr == REG_ADDRS[ch]) rd_data = live[ch];
        end
    end
endmodule

// File: rtl/prot_reg_guard.sv
module prot_reg_guard
    import prg_pkg::*;
#(
    parameter int                ADDR_W        = 12,
    parameter logic [ADDR_W-1:0] CLK_PRE_ADDR  = 12'h010,
    parameter logic [ADDR_W-1:0] CLK_REG_ADDR  = 12'h014,
    parameter logic [ADDR_W-1:0] CLK_POST_ADDR = 12'h018,
    parameter logic [ADDR_W-1:0] PWR_PRE_ADDR  = 12'h020,
    parameter logic [ADDR_W-1:0] PWR_REG_ADDR  = 12'h024,
    parameter logic [ADDR_W-1:0] PWR_POST_ADDR = 12'h028,
    parameter logic [31:0]       CLK_PRE_KEY   = 32'h0000_00AA,
    parameter logic [31:0]       CLK_POST_KEY  = 32'h0000_0055,
    parameter logic [31:0]       PWR_PRE_KEY   = 32'h0000_0001,
    parameter logic [31:0]       PWR_POST_KEY  = 32'h0000_00F4,
    parameter logic [31:0]       CLK_RST_VAL   = 32'h0000_0021,
    parameter logic [31:0]       PWR_RST_VAL   = 32'h0000_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              err_clr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              err_flag,
    output logic              pd_req
);
    localparam logic [NCH-1:0][ADDR_W-1:0] PRE_ADDRS  = {PWR_PRE_ADDR,  CLK_PRE_ADDR};
    localparam logic [NCH-1:0][ADDR_W-1:0] REG_ADDRS  = {PWR_REG_ADDR,  CLK_REG_ADDR};
    localparam logic [NCH-1:0][ADDR_W-1:0] POST_ADDRS = {PWR_POST_ADDR, CLK_POST_ADDR};
    localparam logic [NCH-1:0][PRG_DW-1:0] PRE_KEYS   = {PWR_PRE_KEY,   CLK_PRE_KEY};
    localparam logic [NCH-1:0][PRG_DW-1:0] POST_KEYS  = {PWR_POST_KEY,  CLK_POST_KEY};
    localparam logic [NCH-1:0][PRG_DW-1:0] RST_VALS   = {PWR_RST_VAL,   CLK_RST_VAL};

    logic [NCH-1:0]             hit_pre, hit_reg, hit_post;
    logic [NCH-1:0]             commit, abort;
    logic [NCH-1:0][PRG_DW-1:0] live_val, commit_val;
    logic [PRG_DW-1:0]          live_clk_w, live_pwr_w;

    prg_decode #(
        .ADDR_W     (ADDR_W),
        .PRE_ADDRS  (PRE_ADDRS),
        .REG_ADDRS  (REG_ADDRS),
        .POST_ADDRS (POST_ADDRS)
    ) u_dec (
        .addr     (bus_addr),
        .hit_pre  (hit_pre),
        .hit_reg  (hit_reg),
        .hit_post (hit_post)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_seq
        prg_sequencer #(
            .PRE_KEY  (PRE_KEYS[ch]),
            .POST_KEY (POST_KEYS[ch]),
            .RST_VAL  (RST_VALS[ch])
        ) u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (bus_we),
            .wdata      (bus_wdata),
            .hit_pre    (hit_pre[ch]),
            .hit_reg    (hit_reg[ch]),
            .hit_post   (hit_post[ch]),
            .live       (live_val[ch]),
            .commit_val (commit_val[ch]),
            .commit     (commit[ch]),
            .abort      (abort[ch])
        );
    end

    prg_readmux #(
        .ADDR_W    (ADDR_W),
        .REG_ADDRS (REG_ADDRS)
    ) u_rd (
        .rd_addr (rd_addr),
        .live    (live_val),
        .rd_data (rd_data)
    );

    ctl_regs_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (|abort)       c_d.err = 1'b1;
        else if (err_clr) c_d.err = 1'b0;
        c_d.pd = commit[CH_PWR] && (commit_val[CH_PWR] == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign err_flag   = c_q.err;
    assign pd_req     = c_q.pd;
    assign live_clk_w = live_val[CH_CLK];
    assign live_pwr_w = live_val[CH_PWR];
endmodule

// File: rtl/prg_checker.sv
module prg_checker #(
    parameter int                ADDR_W        = 12,
    parameter logic [ADDR_W-1:0] CLK_PRE_ADDR  = '0,
    parameter logic [ADDR_W-1:0] CLK_POST_ADDR = '0,
    parameter logic [ADDR_W-1:0] PWR_PRE_ADDR  = '0,
    parameter logic [ADDR_W-1:0] PWR_POST_ADDR = '0,
    parameter logic [31:0]       CLK_POST_KEY  = '0,
    parameter logic [31:0]       PWR_POST_KEY  = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              err_clr,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data,
    input logic              err_flag,
    input logic              pd_req,
    input logic [31:0]       live_clk,
    input logic [31:0]       live_pwr
);
    AST_CLK_COMMIT_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(live_clk) |-> $past(bus_we && bus_addr == CLK_POST_ADDR && bus_wdata == CLK_POST_KEY)); // R2
    AST_PWR_COMMIT_ON_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(live_pwr) |-> $past(bus_we && bus_addr == PWR_POST_ADDR && bus_wdata == PWR_POST_KEY)); // R3
    AST_PD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |=> !pd_req); // R10
    AST_PD_ZERO_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        pd_req |-> (live_pwr == '0) && $past(bus_we && bus_addr == PWR_POST_ADDR)); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !err_clr |=> err_flag); // R9
    AST_ERR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr && !bus_we |=> !err_flag); // R9
    AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> $past(bus_we)); // R5
    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == CLK_PRE_ADDR || rd_addr == CLK_POST_ADDR ||
         rd_addr == PWR_PRE_ADDR || rd_addr == PWR_POST_ADDR) |-> rd_data == '0); // R11
endmodule

bind prot_reg_guard prg_checker #(
    .ADDR_W        (ADDR_W),
    .CLK_PRE_ADDR  (CLK_PRE_ADDR),
    .CLK_POST_ADDR (CLK_POST_ADDR),
    .PWR_PRE_ADDR  (PWR_PRE_ADDR),
    .PWR_POST_ADDR (PWR_POST_ADDR),
    .CLK_POST_KEY  (CLK_POST_KEY),
    .PWR_POST_KEY  (PWR_POST_KEY)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .err_clr   (err_clr),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .err_flag  (err_flag),
    .pd_req    (pd_req),
    .live_clk  (live_clk_w),
    .live_pwr  (live_pwr_w)
);

// File: tb/prot_reg_guard_tb.sv
`timescale 1ns/1ps
module prot_reg_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        err_clr = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        err_flag, pd_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    prot_reg_guard dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .err_clr(err_clr), .rd_addr(rd_addr),
        .rd_data(rd_data), .err_flag(err_flag), .pd_req(pd_req)
    );

    // {we, clr, addr, data, exp_clk, exp_pwr, exp_err, exp_pd, tag}
    localparam int VW = 136;
    localparam int NV = 39;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1,1'b0,12'h010,32'h0000_00AA,32'h0000_0021,32'h0000_0003,1'b0,1'b0,"R4 "},
        {1'b1,1'b0,12'h014,32'hDEAD_BEEF,32'h0000_0021,32'h0000_0003,1'b0,1'b0,"R4 "},
        {1'b1,1'b0,12'h018,32'h0000_0055,32'hDEAD_BEEF,32'h0000_0003,1'b0,1'b0,"R2 "},
        {1'b1,1'b0,12'h020,32'h0000_0001,32'hDEAD_BEEF,32'h0000_0003,1'b0,1'b0,"R3 "},
        {1'b1,1'b0,12'h024,32'h0000_0000,32'hDEAD_BEEF,32'h0000_0003,1'b0,1'b0,"R4 "},
        {1'b1,1'b0,12'h028,32'h0000_00F4,32'hDEAD_BEEF,32'h0000_0000,1'b0,1'b1,"R10"},
        {1'b1,1'b0,12'h020,32'h0000_0001,32'hDEAD_BEEF,32'h0000_0000,1'b0,1'b0,"R3 "},
        {1'b1,1'b0,12'h024,32'h0000_0005,32'hDEAD_BEEF,32'h0000_0000,1'b0,1'b0,"R3 "},
        {1'b1,1'b0,12'h028,32'h0000_00F4,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R10"},
        {1'b1,1'b0,12'h014,32'h0000_1234,32'hDEAD_BEEF,32'h0000_0005,1'b1,1'b0,"R6 "},
        {1'b0,1'b1,12'h000,32'h0000_0000,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R9 "},
        {1'b1,1'b0,12'h010,32'h0000_00AB,32'hDEAD_BEEF,32'h0000_0005,1'b1,1'b0,"R5 "},
        {1'b0,1'b1,12'h000,32'h0000_0000,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R9 "},
        {1'b1,1'b0,12'h010,32'h0000_00AA,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R8 "},
        {1'b1,1'b0,12'h014,32'h0000_0777,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R8 "},
        {1'b1,1'b0,12'h028,32'h0000_00F4,32'hDEAD_BEEF,32'h0000_0005,1'b1,1'b0,"R8 "},
        {1'b0,1'b1,12'h000,32'h0000_0000,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R9 "},
        {1'b1,1'b0,12'h018,32'h0000_0055,32'hDEAD_BEEF,32'h0000_0005,1'b1,1'b0,"R6 "},
        {1'b0,1'b1,12'h000,32'h0000_0000,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R9 "},
        {1'b1,1'b0,12'h010,32'h0000_00AA,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R5 "},
        {1'b1,1'b0,12'h014,32'h0000_0099,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R5 "},
        {1'b1,1'b0,12'h018,32'h0000_0056,32'hDEAD_BEEF,32'h0000_0005,1'b1,1'b0,"R5 "},
        {1'b0,1'b1,12'h000,32'h0000_0000,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R9 "},
        {1'b1,1'b0,12'h100,32'h0000_0005,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R12"},
        {1'b1,1'b0,12'h01C,32'h0000_00AA,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R12"},
        {1'b1,1'b0,12'h010,32'h0000_00AA,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R7 "},
        {1'b1,1'b0,12'h014,32'h0000_0ABC,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R7 "},
        {1'b1,1'b0,12'h100,32'h0000_0000,32'hDEAD_BEEF,32'h0000_0005,1'b1,1'b0,"R7 "},
        {1'b0,1'b1,12'h000,32'h0000_0000,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R9 "},
        {1'b1,1'b0,12'h018,32'h0000_0055,32'hDEAD_BEEF,32'h0000_0005,1'b1,1'b0,"R7 "},
        {1'b0,1'b1,12'h000,32'h0000_0000,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R9 "},
        {1'b1,1'b0,12'h020,32'h0000_0001,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R8 "},
        {1'b1,1'b0,12'h014,32'h0000_CAFE,32'hDEAD_BEEF,32'h0000_0005,1'b1,1'b0,"R8 "},
        {1'b0,1'b1,12'h000,32'h0000_0000,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R9 "},
        {1'b1,1'b0,12'h024,32'h0000_CAFE,32'hDEAD_BEEF,32'h0000_0005,1'b1,1'b0,"R8 "},
        {1'b0,1'b1,12'h000,32'h0000_0000,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R9 "},
        {1'b1,1'b0,12'h010,32'h0000_00AA,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R2 "},
        {1'b1,1'b0,12'h014,32'h0000_0000,32'hDEAD_BEEF,32'h0000_0005,1'b0,1'b0,"R2 "},
        {1'b1,1'b0,12'h018,32'h0000_0055,32'h0000_0000,32'h0000_0005,1'b0,1'b0,"R10"}
    };

    task automatic chk(input logic [23:0] tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // drive one bus cycle at the falling edge, sample 1 ns after the rising edge
    task automatic step(input logic we, input logic clr,
                        input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = we; err_clr = clr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_we = 1'b0; err_clr = 1'b0; bus_addr = '0; bus_wdata = '0;
    endtask

    task automatic check_state(input logic [23:0] tag, input logic [31:0] ec,
                               input logic [31:0] ep, input logic ee, input logic epd);
        chk(tag, "err_flag", {31'b0, err_flag}, {31'b0, ee});
        chk(tag, "pd_req", {31'b0, pd_req}, {31'b0, epd});
        rd_addr = 12'h014; #0.3;
        chk(tag, "clk_reg", rd_data, ec);
        rd_addr = 12'h024; #0.3;
        chk(tag, "pwr_reg", rd_data, ep);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_we = 1'b0; err_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        @(posedge clk); #1;
        check_state("R1 ", 32'h21, 32'h3, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][135], VEC[i][134], VEC[i][133:122], VEC[i][121:90]);
            check_state(VEC[i][23:0], VEC[i][89:58], VEC[i][57:26], VEC[i][25], VEC[i][24]);
            idle();
        end

        // R9: a breaking write and a clear in the same cycle leave the flag set
        step(1'b1, 1'b1, 12'h014, 32'h1);
        check_state("R9 ", 32'h0, 32'h5, 1'b1, 1'b0);
        idle();
        step(1'b0, 1'b1, 12'h0, 32'h0);
        check_state("R9 ", 32'h0, 32'h5, 1'b0, 1'b0);
        idle();

        // R11: key addresses and unmapped addresses read zero
        rd_addr = 12'h010; #0.3; chk("R11", "rd key 010", rd_data, 32'h0);
        rd_addr = 12'h018; #0.3; chk("R11", "rd key 018", rd_data, 32'h0);
        rd_addr = 12'h020; #0.3; chk("R11", "rd key 020", rd_data, 32'h0);
        rd_addr = 12'h028; #0.3; chk("R11", "rd key 028", rd_data, 32'h0);
        rd_addr = 12'h100; #0.3; chk("R11", "rd unmapped", rd_data, 32'h0);

        // R1: reset in the middle of a sequence returns everything to idle
        step(1'b1, 1'b0, 12'h010, 32'hAA); idle();
        step(1'b1, 1'b0, 12'h014, 32'h77); idle();
        do_reset();
        @(posedge clk); #1;
        check_state("R1 ", 32'h21, 32'h3, 1'b0, 1'b0);
        step(1'b1, 1'b0, 12'h018, 32'h55);
        check_state("R1 ", 32'h21, 32'h3, 1'b1, 1'b0);
        idle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule